// File: doc/BRIEF.md
# Fixed-Point Iterative Square Root

This block takes an unsigned fixed-point operand in QI.F format and returns its square root in the same QI.F format. `NBITS` is the total width and `FRAC` is the number of fractional bits. The radicand is widened on the right by `FRAC` zero bits. The integer root of that widened value is then the QI.F root, truncated toward zero.

The root is built one bit per clock cycle, starting at the most significant bit. In each cycle a trial bit is set. The bit is kept only if the square of the trial root is not larger than the widened radicand; otherwise it is cleared. The number of iterations is `ceil((NBITS+FRAC)/2)` and does not depend on the data.

An operand enters through a valid/ready handshake. The result leaves through a second valid/ready handshake. A one-cycle completion pulse marks the cycle in which the result first appears.

Top module: `fxp_sqrt`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `done` are 0 and `in_ready` is 1.
- R2: An operand is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 while iterations run and while a result waits to be taken.
- R3: `out_data` equals floor(sqrt(`in_data` * 2^FRAC)). Both values are read as unsigned QI.F numbers.
- R4: `out_valid` rises exactly ITER = ceil((NBITS+FRAC)/2) rising edges after the accepting edge, whatever the data. With the defaults NBITS=16 and FRAC=8, ITER is 12.
- R5: `done` is high for exactly one cycle: the first cycle in which `out_valid` is high.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. On an edge with both high, `out_valid` drops and `in_ready` returns to 1 in the next cycle.
- R7: An input of 0 gives 0. The largest input (all ones) gives its truncated root with no overflow; for the defaults, 0xFFFF gives 0x0FFF.
- R8: `in_valid` and `in_data` have no effect while an operation is running or a result is held; the result returned is that of the accepted operand.
- R9: At every cycle the square of the partial root is no larger than the widened radicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_data | input | NBITS | Operand, unsigned QI.F |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | NBITS | Root, unsigned QI.F |
| done | output | 1 | One-cycle pulse when the result first appears |

## Verification
The assertions check four things on every cycle:
- the handshakes are never open at the same time;
- a held result stays valid and stable until it is taken;
- the completion pulse lasts one cycle and coincides with a valid result;
- the partial root never squares above the radicand.

The numeric value of the root, the exact fixed latency, and the fact that operands offered during a busy period are ignored can only be shown by the bench's scenarios. Those scenarios include zero, the all-ones input, exact squares and seeded random operands, each compared with a reference root computed in the bench.

// File: rtl/fxp_sqrt_pkg.sv
package fxp_sqrt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    function automatic int unsigned iter_count(input int unsigned nbits, input int unsigned frac);
        return (nbits + frac + 1) / 2;
    endfunction

endpackage

// File: rtl/fxp_sqrt_step.sv
module fxp_sqrt_step #(
    parameter int unsigned ROOT_W = 12,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [ROOT_W-1:0]   root_cur,
    input  logic [2*ROOT_W-1:0] radicand,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic [ROOT_W-1:0]   root_nxt
);
    localparam int unsigned SQ_W = 2 * ROOT_W;

    logic [ROOT_W-1:0] trial;
    logic [SQ_W-1:0]   trial_w;
    logic [SQ_W-1:0]   trial_sq;

    always_comb begin
        trial    = root_cur | (ROOT_W'(1) << bit_idx);
        trial_w  = SQ_W'(trial);
        trial_sq = trial_w * trial_w;
        root_nxt = (trial_sq <= radicand) ? trial : root_cur;
    end
endmodule

// File: rtl/fxp_sqrt_ctrl.sv
module fxp_sqrt_ctrl
    import fxp_sqrt_pkg::*;
#(
    parameter int unsigned ITER  = 12,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             done,
    output logic             load,
    output logic             step_en,
    output logic [IDX_W-1:0] bit_idx
);
    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    nxt_d.phase = PH_RUN;
                    nxt_d.idx   = IDX_W'(ITER - 1);
                end
            end
            PH_RUN: begin
                if (cur_q.idx == '0) begin
                    nxt_d.phase = PH_HOLD;
                    nxt_d.done  = 1'b1;
                end else begin
                    nxt_d.idx = cur_q.idx - IDX_W'(1);
                end
            end
            PH_HOLD: begin
                if (out_ready) nxt_d.phase = PH_IDLE;
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.phase <= PH_IDLE;
            cur_q.idx   <= '0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_ready  = (cur_q.phase == PH_IDLE);
    assign out_valid = (cur_q.phase == PH_HOLD);
    assign done      = cur_q.done;
    assign load      = in_ready && in_valid;
    assign step_en   = (cur_q.phase == PH_RUN);
    assign bit_idx   = cur_q.idx;

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && !done && in_ready));
    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst) !(in_ready && out_valid));
    // R5
    done_valid_chk: assert property (@(posedge clk) disable iff (rst) done |-> out_valid);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R6
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> out_valid);
    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst) (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: rtl/fxp_sqrt.sv
module fxp_sqrt
    import fxp_sqrt_pkg::*;
#(
    parameter int unsigned NBITS = 16,
    parameter int unsigned FRAC  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NBITS-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [NBITS-1:0] out_data,
    output logic             done
);
    localparam int unsigned ITER   = iter_count(NBITS, FRAC);
    localparam int unsigned ROOT_W = ITER;
    localparam int unsigned SQ_W   = 2 * ROOT_W;
    localparam int unsigned IDX_W  = (ITER > 1) ? $clog2(ITER) : 1;

    typedef struct packed {
        logic [SQ_W-1:0]   rad;
        logic [ROOT_W-1:0] root;
    } dp_t;

    dp_t dp_q, dp_d;

    logic             load;
    logic             step_en;
    logic [IDX_W-1:0] bit_idx;
    logic [ROOT_W-1:0] root_nxt;

    fxp_sqrt_ctrl #(
        .ITER  (ITER),
        .IDX_W (IDX_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .done      (done),
        .load      (load),
        .step_en   (step_en),
        .bit_idx   (bit_idx)
    );

    fxp_sqrt_step #(
        .ROOT_W (ROOT_W),
        .IDX_W  (IDX_W)
    ) step_i (
        .root_cur (dp_q.root),
        .radicand (dp_q.rad),
        .bit_idx  (bit_idx),
        .root_nxt (root_nxt)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.rad  = SQ_W'(in_data) << FRAC;
            dp_d.root = '0;
        end else if (step_en) begin
            dp_d.root = root_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q.rad  <= '0;
            dp_q.root <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign out_data = NBITS'(dp_q.root);

    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));
    // R9
    root_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ((SQ_W'(dp_q.root) * SQ_W'(dp_q.root)) <= dp_q.rad));
    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(dp_q.rad));
endmodule

// File: tb/fxp_sqrt_tb_top.sv
module fxp_sqrt_tb_top;
    localparam int NBITS  = 16;
    localparam int FRAC   = 8;
    localparam int ITER   = (NBITS + FRAC + 1) / 2;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [NBITS-1:0] in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [NBITS-1:0] out_data;
    logic             done;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    fxp_sqrt #(.NBITS(NBITS), .FRAC(FRAC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .done      (done)
    );

    function automatic longint ref_root(input longint v);
        longint lo = 0;
        longint hi = 64'd1 << 32;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) / 2;
            if (mid * mid <= v) lo = mid;
            else hi = mid - 1;
        end
        return lo;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [NBITS-1:0] x, input int hold, input bit noisy);
        longint exp_v;
        int lat;
        int guard;
        logic [NBITS-1:0] first;
        exp_v = ref_root(longint'(x) << FRAC) & ((64'd1 << NBITS) - 1);
        guard = 0;
        while (!in_ready && guard < 1000) begin @(negedge clk); guard++; end
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        check("R2 in_ready low after accept", in_ready, 0);
        if (noisy) begin
            in_data = ~x;
        end else begin
            in_valid = 1'b0;
        end
        lat = 0;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
            if (noisy) in_data = NBITS'($urandom);
        end
        in_valid = 1'b0;
        check("R4 latency", lat, ITER);
        check("R5 done with first valid", done, 1);
        check(noisy ? "R8 R3 root with busy noise" : "R3 root value", out_data, exp_v);
        first = out_data;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R5 done single cycle", done, 0);
            check("R6 held valid", out_valid, 1);
            check("R6 held data", out_data, first);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R6 released valid", out_valid, 0);
        check("R6 in_ready back", in_ready, 1);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h51a7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 done after reset", done, 0);
        check("R1 in_ready after reset", in_ready, 1);

        run_op('0, 1, 1'b0);                 // R7 zero
        run_op('1, 2, 1'b0);                 // R7 maximum
        check("R7 max root", out_data, 16'h0FFF);
        run_op(NBITS'(4 << FRAC), 0, 1'b0);  // exact square 4.0 -> 2.0
        run_op(NBITS'(1 << FRAC), 3, 1'b1);  // 1.0 -> 1.0 with busy noise
        run_op(NBITS'(2 << FRAC), 0, 1'b0);  // irrational result truncated
        run_op(NBITS'(1), 1, 1'b0);          // smallest nonzero
        for (int n = 0; n < 40; n++) begin
            run_op(NBITS'($urandom), int'($urandom % 4), bit'($urandom % 2));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule